// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a 1-Kbit serial EEPROM with a three-wire interface. A host drives select `s_i`, serial clock `c_i` and serial data `d_i`, and reads `q_o`. The block runs on a faster system clock `clk_i`. It brings the three serial pins into that domain and acts on the rising edges of the serial clock that it detects there.

A frame opens with a start bit. A two-bit opcode follows, then an address, and for a write the data follows after the address. The parameter `ORG16` picks the organisation: 64 words of 16 bits, or 128 bytes of 8 bits. Writes and erases are not applied at once. Each one is held pending and is committed only when select drops cleanly. A self-timed programming cycle of `PROG_CYCLES` system clocks then runs. During that cycle `q_o` reports busy or ready status in place of data.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, `q_o` is 1, every cell of the array reads as all ones, and write permission is off.
- R2: While select is high and the block is idle, zero bits on `d_i` are skipped. The first 1 is the start bit. Two opcode bits follow, then the address bits (6 bits for 16-bit words, 7 bits for bytes). All bits are sent MSB first and are sampled on rising edges of `c_i`.
- R3: Opcode 10 is a read. After the last address bit is sampled, `q_o` drives a dummy 0. Each later rising edge of `c_i` then presents the next data bit, MSB first.
- R4: Opcode 01 is a write. It takes the word-width data bits after the address. When select then falls, a programming cycle starts, and the word is stored at the end of that cycle.
- R5: A pending write or erase is dropped if a rising edge of `c_i` comes after its last bit and before select falls. This includes an edge seen in the same system cycle as the fall.
- R6: Opcode 11 is an erase. Once the address is complete, the next fall of select starts a programming cycle that sets the addressed word to all ones.
- R7: Opcode 00 carries a two-bit selector in the top address bits: 11 sets write permission and 00 clears it. The remaining address bits are don't-care. Writes and erases made while permission is off leave the array unchanged.
- R8: While a programming cycle runs, `q_o` is 0 whenever select is high. All serial input is ignored during this time, including complete frames and select falls.
- R9: A programming cycle lasts `PROG_CYCLES` system clocks. After it ends, `q_o` is 1 while select is high.
- R10: When select goes low in the middle of a frame, the frame is abandoned without effect, and the next frame decodes from its start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s_i | input | 1 | Chip select, active high |
| c_i | input | 1 | Serial clock |
| d_i | input | 1 | Serial data in |
| q_o | output | 1 | Serial data out, or busy/ready status |

## Verification
The hard case is the last bit of a write. After it, a fall of select commits the write, while a further rising edge of the serial clock cancels it. The bench provokes both outcomes. It sends one extra clock pulse after the data. It also drops select and raises the clock in the same simulation step, so that both edges reach the synchroniser in the same system cycle. In each case it judges the result by confirming that no busy status appears and that the word reads back unchanged. A second overlap occurs when a complete write frame arrives while a programming cycle is still running. The bench judges that case by reading back both addresses once the block reports ready.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } mw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SEL_EN  = 2'b11;
  localparam logic [1:0] SEL_DIS = 2'b00;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o
);
  logic [N-1:0] meta_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= 1'b0;
        lvl_o[i]  <= 1'b0;
      end else begin
        meta_q[i] <= pin_i[i];
        lvl_o[i]  <= meta_q[i];
      end
    end
  end
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int unsigned CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter bit          ORG16       = 1'b1,
  parameter int unsigned PROG_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  input  logic c_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned DW = ORG16 ? 16 : 8;
  localparam int unsigned AW = ORG16 ? 6 : 7;
  localparam int unsigned BW = $clog2(DW + 1);

  logic [2:0] lvl;
  logic       s_lvl, c_lvl, d_lvl;
  logic       s_prev_q, c_prev_q;
  logic       s_fall, c_rise;

  mw_pin_sync #(.N(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i ({d_i, c_i, s_i}),
    .lvl_o (lvl)
  );

  assign s_lvl = lvl[0];
  assign c_lvl = lvl[1];
  assign d_lvl = lvl[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_prev_q <= 1'b0;
      c_prev_q <= 1'b0;
    end else begin
      s_prev_q <= s_lvl;
      c_prev_q <= c_lvl;
    end
  end

  assign s_fall = s_prev_q & ~s_lvl;
  assign c_rise = ~c_prev_q & c_lvl;

  mw_state_e     st_q;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [BW-1:0] cnt_q;
  logic          wen_q, pend_q, q_bit_q;
  logic [AW-1:0] addr_nxt;
  logic [DW-1:0] rdata;
  logic          busy, prog_done, prog_start;

  assign addr_nxt = {addr_q[AW-2:0], d_lvl};

  // commit only on a clean select fall, with no clock edge in the same cycle
  assign prog_start = ~busy & s_fall & pend_q & ~c_rise;

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(prog_start),
    .busy_o (busy),
    .done_o (prog_done)
  );

  mw_array #(.DW(DW), .AW(AW)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (prog_done),
    .waddr_i(addr_q),
    .wdata_i((op_q == OP_ERASE) ? {DW{1'b1}} : data_q),
    .raddr_i(addr_nxt),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_EXT;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      wen_q   <= 1'b0;
      pend_q  <= 1'b0;
      q_bit_q <= 1'b1;
    end else if (busy) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else if (!s_lvl) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else if (c_rise) begin
      unique case (st_q)
        ST_IDLE: if (d_lvl) begin
          st_q  <= ST_OP;
          cnt_q <= '0;
        end
        ST_OP: begin
          op_q <= {op_q[0], d_lvl};
          if (cnt_q == BW'(1)) begin
            st_q  <= ST_ADDR;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ADDR: begin
          addr_q <= addr_nxt;
          if (cnt_q == BW'(AW - 1)) begin
            cnt_q <= '0;
            unique case (op_q)
              OP_READ: begin
                data_q  <= rdata;
                q_bit_q <= 1'b0;
                st_q    <= ST_READ;
              end
              OP_WRITE: st_q <= ST_DATA;
              OP_ERASE: begin
                pend_q <= wen_q;
                st_q   <= ST_DONE;
              end
              default: begin
                if (addr_nxt[AW-1 -: 2] == SEL_EN)  wen_q <= 1'b1;
                if (addr_nxt[AW-1 -: 2] == SEL_DIS) wen_q <= 1'b0;
                st_q <= ST_DONE;
              end
            endcase
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          data_q <= {data_q[DW-2:0], d_lvl};
          if (cnt_q == BW'(DW - 1)) begin
            pend_q <= wen_q;
            st_q   <= ST_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_READ: begin
          q_bit_q <= data_q[DW-1];
          data_q  <= {data_q[DW-2:0], 1'b1};
        end
        default: pend_q <= 1'b0; // late clock edge cancels the commit
      endcase
    end
  end

  always_comb begin
    if (busy)                 q_o = ~s_lvl;
    else if (st_q == ST_READ) q_o = q_bit_q;
    else                      q_o = 1'b1;
  end
endmodule

module mw_eeprom_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic s_lvl,
  input logic busy,
  input logic wen,
  input logic mem_we,
  input logic q_o
);
  // R8
  busy_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && s_lvl |-> !q_o);
  // R8
  wen_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) |-> $stable(wen));
  // R4
  start_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !s_lvl);
  // R4
  store_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> !busy);
  // R9
  ready_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> q_o);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .s_lvl (s_lvl),
  .busy  (busy),
  .wen   (wen_q),
  .mem_we(prog_done),
  .q_o   (q_o)
);

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 4;
  localparam int PROG = 400;
  localparam int DW = 16;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic s_i = 1'b0, c_i = 1'b0, d_i = 1'b0;
  logic q_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mw_eeprom #(.ORG16(1'b1), .PROG_CYCLES(PROG)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .s_i(s_i), .c_i(c_i), .d_i(d_i), .q_o(q_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse(input bit b);
    d_i = b; wt(HB);
    c_i = 1'b1; wt(HB);
    c_i = 1'b0; wt(HB);
  endtask

  task automatic sel_on();
    s_i = 1'b1; wt(HB);
  endtask

  task automatic sel_off();
    d_i = 1'b0; s_i = 1'b0; wt(2 * HB);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a);
    pulse(1'b1); pulse(op[1]); pulse(op[0]);
    for (int i = AW - 1; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic read_word(input logic [AW-1:0] a, output logic [DW-1:0] v, output bit dummy);
    sel_on();
    send_hdr(2'b10, a);
    dummy = q_o;
    for (int i = DW - 1; i >= 0; i--) begin
      pulse(1'b0);
      v[i] = q_o;
    end
    sel_off();
  endtask

  // mode 0: clean commit, 1: extra clock pulse, 2: select fall and clock rise together
  task automatic send_write(input logic [AW-1:0] a, input logic [DW-1:0] v, input int mode);
    sel_on();
    send_hdr(2'b01, a);
    for (int i = DW - 1; i >= 0; i--) pulse(v[i]);
    if (mode == 1) pulse(1'b0);
    if (mode == 2) begin
      s_i = 1'b0; c_i = 1'b1; wt(HB);
      c_i = 1'b0; wt(HB);
    end else begin
      sel_off();
    end
  endtask

  task automatic send_ext(input logic [1:0] sel);
    sel_on();
    send_hdr(2'b00, {sel, {(AW - 2){1'b0}}});
    sel_off();
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    s_i = 1'b1; wt(HB);
    chk(q_o == 1'b0, {req, " busy"}, q_o, 0);
    while (q_o == 1'b0 && n < PROG + 50) begin
      @(negedge clk); n++;
    end
    chk(q_o == 1'b1 && n < PROG, {req, " ready"}, n, PROG);
    sel_off();
  endtask

  task automatic expect_word(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    logic [DW-1:0] v;
    bit dm;
    read_word(a, v, dm);
    chk(v == e, req, v, e);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    bit dm;
    chk(q_o == 1'b1, "R1 q after reset", q_o, 1);
    read_word(6'd5, v, dm);
    chk(v == 16'hFFFF, "R1 erased array", v, 16'hFFFF);
    chk(dm == 1'b0, "R3 dummy zero", dm, 0);
  endtask

  task automatic t_locked();
    send_write(6'd2, 16'h0F0F, 0);
    s_i = 1'b1; wt(HB);
    chk(q_o == 1'b1, "R7 no cycle while locked", q_o, 1);
    sel_off();
    expect_word(6'd2, 16'hFFFF, "R7 locked write ignored");
  endtask

  task automatic t_write_basic();
    send_ext(2'b11);
    sel_on();
    pulse(1'b0); pulse(1'b0); // R2 leading zeros skipped
    s_i = 1'b0; wt(2 * HB);
    sel_on();
    send_hdr(2'b01, 6'd3);
    for (int i = DW - 1; i >= 0; i--) pulse(16'h1234 >> i);
    sel_off();
    wait_ready("R8 R9 write");
    expect_word(6'd3, 16'h1234, "R4 R2 stored word");
    send_write(6'd63, 16'hA5C3, 0);
    wait_ready("R9 top addr");
    expect_word(6'd63, 16'hA5C3, "R4 R3 top address");
  endtask

  task automatic t_cancel();
    send_write(6'd7, 16'h0000, 1);
    s_i = 1'b1; wt(HB);
    chk(q_o == 1'b1, "R5 extra edge no busy", q_o, 1);
    sel_off();
    expect_word(6'd7, 16'hFFFF, "R5 extra edge cancel");
    send_write(6'd8, 16'h0000, 2);
    s_i = 1'b1; wt(HB);
    chk(q_o == 1'b1, "R5 same-cycle no busy", q_o, 1);
    sel_off();
    expect_word(6'd8, 16'hFFFF, "R5 same-cycle cancel");
  endtask

  task automatic t_erase();
    sel_on();
    send_hdr(2'b11, 6'd3);
    sel_off();
    wait_ready("R6 erase");
    expect_word(6'd3, 16'hFFFF, "R6 erased word");
  endtask

  task automatic t_busy_ignore();
    send_write(6'd10, 16'h5555, 0);
    send_write(6'd11, 16'h3333, 0);
    wait_ready("R8 overlap");
    expect_word(6'd10, 16'h5555, "R8 first write kept");
    expect_word(6'd11, 16'hFFFF, "R8 frame during busy ignored");
  endtask

  task automatic t_disable();
    send_ext(2'b00);
    send_write(6'd20, 16'h00FF, 0);
    expect_word(6'd20, 16'hFFFF, "R7 disabled write ignored");
  endtask

  task automatic t_abort();
    send_ext(2'b11);
    sel_on();
    pulse(1'b1); pulse(1'b0); pulse(1'b1);
    pulse(1'b0); pulse(1'b1); pulse(1'b0);
    sel_off();
    s_i = 1'b1; wt(HB);
    chk(q_o == 1'b1, "R10 abort no busy", q_o, 1);
    sel_off();
    expect_word(6'd63, 16'hA5C3, "R10 resync after abort");
    expect_word(6'd21, 16'hFFFF, "R10 aborted frame no write");
  endtask

  initial begin
    wt(5);
    rst_ni = 1'b1;
    wt(5);
    t_reset();
    t_locked();
    t_write_basic();
    t_cancel();
    t_erase();
    t_busy_ignore();
    t_disable();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule